// File: doc/BRIEF.md
# PHY Link State Monitor

This block follows the link of an Ethernet PHY from status samples that a separate management-bus engine fetches. Each sample carries the 16-bit basic status register of the PHY and a 5-bit vendor status word holding the link, signal-detect, 10 Mb/s, 100 Mb/s and full-duplex flags. The block keeps the link in one of three states (UNKNOWN, DOWN, UP) and applies asymmetric debouncing. A drop from UP is taken at once. Entry into UP waits until the status value has been steady for a settle window, autonegotiation has finished (when it is enabled) and the vendor word agrees.

On every change into or out of UP the block emits a one-cycle report pulse and latches speed and duplex. It also counts link-ups and link-drops. Changes between DOWN and UNKNOWN update the state without a report. All time windows are counted in ticks of a time-base enable input, so simulation can use short windows.

After the PHY has been reprogrammed, a restart pulse opens a bounded polling window. During that window the block asks the management engine for fresh samples at a fixed interval. It asks at once after any sample that changed the stored status or the state. The window closes when a sample is accepted as UP or when the window length expires.

Top module: `link_state_monitor`

## Requirements
- R1: After reset the state is UNKNOWN (code 0), speed and duplex are 0, both counters are 0, and neither the report pulse nor the polling window is active.
- R2: A valid sample whose status differs from the stored one replaces it and clears the tick count. The settle condition holds only for an unchanged sample whose tick count has reached SETTLE_TICKS.
- R3: The candidate state is UP (code 2) when status bit 2 is set and DOWN (code 1) otherwise. A status of 0xFFFF always gives DOWN.
- R4: With the state UP, a sample with status bit 2 clear moves the state to DOWN on that sample, whatever the settle condition.
- R5: In all cases not covered by R3's 0xFFFF rule or by R4, a sample taken before the settle condition holds gives UNKNOWN.
- R6: Once settled, the candidate is kept when status bit 5 (autonegotiation complete) is set. When bit 5 is clear, the candidate becomes DOWN if an_enable is high and is kept if an_enable is low.
- R7: An UP candidate becomes UNKNOWN unless vendor bit 0 (link) and bit 1 (signal) are both set and exactly one of bit 2 (10 Mb/s) and bit 3 (100 Mb/s) is set.
- R8: On entry into UP, speed becomes 1 for 10 Mb/s or 2 for 100 Mb/s, and duplex becomes 2 if vendor bit 4 is set and 1 otherwise. On leaving UP both return to 0.
- R9: The report pulse lasts one cycle, one cycle after a sample that moves the state into or out of UP. Changes between DOWN and UNKNOWN give no pulse.
- R10: The link-up counter counts entries into UP and the link-drop counter counts exits from UP.
- R11: A restart pulse opens a polling window. In the window, poll_req pulses every POLL_TICKS ticks. The window closes when a sample is accepted as UP or after RESTART_TICKS ticks.
- R12: Inside the window, a sample that changes the stored status or the state raises poll_req in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per time unit |
| an_enable | input | 1 | Autonegotiation is enabled in the PHY |
| restart | input | 1 | Pulse: PHY was reprogrammed, open polling window |
| samp_valid | input | 1 | Sample qualifier |
| samp_status | input | 16 | PHY basic status register value |
| samp_vendor | input | 5 | Vendor status: link, signal, 10M, 100M, full duplex (bits 0..4) |
| link_state | output | 2 | 0 UNKNOWN, 1 DOWN, 2 UP |
| link_speed | output | 2 | 0 none, 1 10 Mb/s, 2 100 Mb/s |
| link_duplex | output | 2 | 0 unknown, 1 half, 2 full |
| link_report | output | 1 | One-cycle pulse on entry into or exit from UP |
| up_count | output | CNT_W | Link-up events |
| drop_count | output | CNT_W | Link-drop events |
| poll_req | output | 1 | Request for a fresh sample |
| polling | output | 1 | Restart polling window open |

## Verification
The hardest situation to reach is a sample that arrives with its status unchanged after exactly the settle count. Only then do the rules on autonegotiation completion and vendor consistency decide the outcome. The stimulus sends a status value once, idles for more ticks than the settle window, and then sends the same value again with different vendor words and an_enable settings. A reference model compares every output on every clock, which also covers the timing of the poll requests inside the restart window.

// File: rtl/lsm_pkg.sv
// Shared types and field positions for the link state monitor.
// Assumes: status word is the PHY basic status register layout.
package lsm_pkg;
    typedef enum logic [1:0] {
        LS_UNKNOWN = 2'd0,
        LS_DOWN    = 2'd1,
        LS_UP      = 2'd2
    } link_t;

    localparam int VEND_W   = 5;
    localparam int VB_LINK  = 0;
    localparam int VB_SIG   = 1;
    localparam int VB_10M   = 2;
    localparam int VB_100M  = 3;
    localparam int VB_FDX   = 4;

    localparam int SB_LINK   = 2;
    localparam int SB_ANDONE = 5;
    localparam logic [15:0] ST_INVALID = 16'hFFFF;

    localparam logic [1:0] SPD_NONE = 2'd0;
    localparam logic [1:0] SPD_10   = 2'd1;
    localparam logic [1:0] SPD_100  = 2'd2;
    localparam logic [1:0] DPX_UNK  = 2'd0;
    localparam logic [1:0] DPX_HALF = 2'd1;
    localparam logic [1:0] DPX_FULL = 2'd2;
endpackage

// File: rtl/lsm_sample_track.sv
// Stores the last status value and counts ticks since it last changed.
// Assumes: samp_status is meaningful only while samp_valid is high.
module lsm_sample_track #(
    parameter int SETTLE_TICKS = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        samp_valid,
    input  logic [15:0] samp_status,
    output logic        changed,
    output logic        settled
);
    localparam int AW = $clog2(SETTLE_TICKS + 1);
    localparam logic [AW-1:0] AGE_MAX = AW'(SETTLE_TICKS);

    logic [15:0]   stored_q;
    logic [AW-1:0] age_q;

    // Detect a new status value and the settle condition for this sample.
    always_comb begin
        changed = samp_valid && (samp_status != stored_q);
        settled = !changed && (age_q == AGE_MAX);
    end

    // Keep the stored value and the saturating tick age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
            age_q    <= '0;
        end else if (changed) begin
            stored_q <= samp_status;
            age_q    <= '0;
        end else if (tick && age_q != AGE_MAX) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_age_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= AGE_MAX);
    p_change_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (age_q == '0));
endmodule

// File: rtl/lsm_judge.sv
// Combinational decision of the next link state from one sample.
// Assumes: settled comes from lsm_sample_track for the same sample.
module lsm_judge
    import lsm_pkg::*;
(
    input  logic [15:0]       status,
    input  logic [VEND_W-1:0] vendor,
    input  logic              settled,
    input  logic              an_enable,
    input  logic [1:0]        cur_state,
    output logic [1:0]        cand,
    output logic              vendor_ok
);
    // Apply the ordered debounce rules, then the vendor consistency check.
    always_comb begin
        vendor_ok = vendor[VB_LINK] && vendor[VB_SIG]
                    && (vendor[VB_10M] ^ vendor[VB_100M]);
        cand = status[SB_LINK] ? LS_UP : LS_DOWN;
        if (status == ST_INVALID)
            cand = LS_DOWN;
        else if (cur_state == LS_UP && !status[SB_LINK])
            cand = LS_DOWN;
        else if (!settled)
            cand = LS_UNKNOWN;
        else if (!status[SB_ANDONE] && an_enable)
            cand = LS_DOWN;
        if (cand == LS_UP && !vendor_ok)
            cand = LS_UNKNOWN;
    end
endmodule

// File: rtl/lsm_restart.sv
// Bounded polling window opened after the PHY is reprogrammed.
// Assumes: restart is a pulse; tick paces both interval and window.
module lsm_restart #(
    parameter int POLL_TICKS    = 60,
    parameter int RESTART_TICKS = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic kick,
    input  logic up_accept,
    output logic poll_req,
    output logic polling
);
    localparam int PW = $clog2(POLL_TICKS + 1);
    localparam int RW = $clog2(RESTART_TICKS + 1);
    localparam logic [PW-1:0] P_LAST = PW'(POLL_TICKS - 1);
    localparam logic [RW-1:0] R_LAST = RW'(RESTART_TICKS - 1);

    logic [PW-1:0] pcnt_q;
    logic [RW-1:0] rcnt_q;

    // Run the window timer, the interval timer and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polling  <= 1'b0;
            poll_req <= 1'b0;
            pcnt_q   <= '0;
            rcnt_q   <= '0;
        end else if (restart) begin
            polling  <= 1'b1;
            poll_req <= 1'b0;
            pcnt_q   <= '0;
            rcnt_q   <= '0;
        end else if (polling) begin
            if (up_accept || (tick && rcnt_q == R_LAST)) begin
                polling  <= 1'b0;
                poll_req <= 1'b0;
            end else begin
                poll_req <= (tick && pcnt_q == P_LAST) || kick;
                if (tick) begin
                    rcnt_q <= rcnt_q + 1'b1;
                    pcnt_q <= (pcnt_q == P_LAST) ? '0 : pcnt_q + 1'b1;
                end
            end
        end else begin
            poll_req <= 1'b0;
        end
    end

    p_poll_in_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> polling);
    p_restart_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> polling);
    p_kick_polls_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (polling && !restart && kick && !up_accept && !tick) |=> poll_req);
endmodule

// File: rtl/link_state_monitor.sv
// Link state tracker: debounces PHY status samples into UP/DOWN/UNKNOWN,
// reports UP entries/exits with speed and duplex, counts events, and
// paces re-polling after a PHY restart.
// Assumes: samples come from an external management-bus engine.
module link_state_monitor
    import lsm_pkg::*;
#(
    parameter int SETTLE_TICKS  = 300,
    parameter int POLL_TICKS    = 60,
    parameter int RESTART_TICKS = 1200,
    parameter int CNT_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              an_enable,
    input  logic              restart,
    input  logic              samp_valid,
    input  logic [15:0]       samp_status,
    input  logic [VEND_W-1:0] samp_vendor,
    output logic [1:0]        link_state,
    output logic [1:0]        link_speed,
    output logic [1:0]        link_duplex,
    output logic              link_report,
    output logic [CNT_W-1:0]  up_count,
    output logic [CNT_W-1:0]  drop_count,
    output logic              poll_req,
    output logic              polling
);
    logic       changed, settled, vendor_ok;
    logic [1:0] cand;
    logic       enter_up, leave_up, kick, up_accept;

    lsm_sample_track #(.SETTLE_TICKS(SETTLE_TICKS)) u_track (
        .clk(clk), .rst_n(rst_n), .tick(tick), .samp_valid(samp_valid),
        .samp_status(samp_status), .changed(changed), .settled(settled)
    );

    lsm_judge u_judge (
        .status(samp_status), .vendor(samp_vendor), .settled(settled),
        .an_enable(an_enable), .cur_state(link_state), .cand(cand),
        .vendor_ok(vendor_ok)
    );

    // Classify the transition this sample would cause.
    always_comb begin
        enter_up  = samp_valid && cand == LS_UP && link_state != LS_UP;
        leave_up  = samp_valid && cand != LS_UP && link_state == LS_UP;
        kick      = samp_valid && (changed || cand != link_state);
        up_accept = samp_valid && cand == LS_UP;
    end

    lsm_restart #(.POLL_TICKS(POLL_TICKS), .RESTART_TICKS(RESTART_TICKS)) u_rs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .kick(kick), .up_accept(up_accept), .poll_req(poll_req),
        .polling(polling)
    );

    // Accept the candidate state, latch speed/duplex and pulse the report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_state  <= LS_UNKNOWN;
            link_speed  <= SPD_NONE;
            link_duplex <= DPX_UNK;
            link_report <= 1'b0;
        end else begin
            link_report <= enter_up || leave_up;
            if (samp_valid) link_state <= cand;
            if (enter_up) begin
                link_speed  <= samp_vendor[VB_100M] ? SPD_100 : SPD_10;
                link_duplex <= samp_vendor[VB_FDX] ? DPX_FULL : DPX_HALF;
            end else if (leave_up) begin
                link_speed  <= SPD_NONE;
                link_duplex <= DPX_UNK;
            end
        end
    end

    // Count link-up and link-drop events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_count   <= '0;
            drop_count <= '0;
        end else begin
            if (enter_up) up_count   <= up_count + 1'b1;
            if (leave_up) drop_count <= drop_count + 1'b1;
        end
    end

    p_fast_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && link_state == LS_UP && !samp_status[SB_LINK])
        |=> link_state == LS_DOWN);
    p_invalid_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && samp_status == ST_INVALID) |=> link_state == LS_DOWN);
    p_vendor_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !vendor_ok) |=> link_state != LS_UP);
    p_report_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_report |-> ((link_state == LS_UP) != ($past(link_state) == LS_UP)));
    p_up_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_count != $past(up_count)) |-> (link_report && link_state == LS_UP));
    p_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != LS_UP) |-> (link_speed == SPD_NONE && link_duplex == DPX_UNK));
endmodule

// File: tb/tb_link_state_monitor.sv
module tb_link_state_monitor;
    localparam int SETTLE  = 8;
    localparam int POLL    = 5;
    localparam int RESTART = 40;
    localparam int CW      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick, an_enable, restart, samp_valid;
    logic [15:0] samp_status;
    logic [4:0]  samp_vendor;
    logic [1:0]  link_state, link_speed, link_duplex;
    logic        link_report, poll_req, polling;
    logic [CW-1:0] up_count, drop_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    link_state_monitor #(.SETTLE_TICKS(SETTLE), .POLL_TICKS(POLL),
        .RESTART_TICKS(RESTART), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .an_enable(an_enable),
        .restart(restart), .samp_valid(samp_valid), .samp_status(samp_status),
        .samp_vendor(samp_vendor), .link_state(link_state),
        .link_speed(link_speed), .link_duplex(link_duplex),
        .link_report(link_report), .up_count(up_count),
        .drop_count(drop_count), .poll_req(poll_req), .polling(polling)
    );

    // Reference model, written from the requirements.
    int m_state, m_spd, m_dpx, m_rep, m_up, m_drop, m_poll, m_act;
    int m_stat, m_age, m_pcnt, m_rcnt;

    always @(posedge clk) begin
        int c;
        bit chg, set, vok, lnk;
        if (!rst_n) begin
            m_state = 0; m_spd = 0; m_dpx = 0; m_rep = 0; m_up = 0; m_drop = 0;
            m_poll = 0; m_act = 0; m_stat = 0; m_age = 0; m_pcnt = 0; m_rcnt = 0;
        end else begin
            chg = samp_valid && (int'(samp_status) != m_stat);
            set = !chg && (m_age == SETTLE);
            lnk = samp_status[2];
            vok = samp_vendor[0] && samp_vendor[1] && (samp_vendor[2] != samp_vendor[3]);
            c = lnk ? 2 : 1;
            if (samp_status == 16'hFFFF) c = 1;
            else if (m_state == 2 && !lnk) c = 1;
            else if (!set) c = 0;
            else if (!samp_status[5] && an_enable) c = 1;
            if (c == 2 && !vok) c = 0;
            // restart window
            if (restart) begin
                m_act = 1; m_poll = 0; m_pcnt = 0; m_rcnt = 0;
            end else if (m_act != 0) begin
                if ((samp_valid && c == 2) || (tick && m_rcnt == RESTART - 1)) begin
                    m_act = 0; m_poll = 0;
                end else begin
                    m_poll = ((tick && m_pcnt == POLL - 1) ||
                              (samp_valid && (chg || c != m_state))) ? 1 : 0;
                    if (tick) begin
                        m_rcnt++;
                        m_pcnt = (m_pcnt == POLL - 1) ? 0 : m_pcnt + 1;
                    end
                end
            end else m_poll = 0;
            m_rep = 0;
            if (samp_valid) begin
                if (c == 2 && m_state != 2) begin
                    m_rep = 1; m_up = (m_up + 1) % 65536;
                    m_spd = samp_vendor[3] ? 2 : 1;
                    m_dpx = samp_vendor[4] ? 2 : 1;
                end else if (c != 2 && m_state == 2) begin
                    m_rep = 1; m_drop = (m_drop + 1) % 65536;
                    m_spd = 0; m_dpx = 0;
                end
                m_state = c;
            end
            if (chg) begin m_stat = int'(samp_status); m_age = 0; end
            else if (tick && m_age != SETTLE) m_age++;
        end
    end

    task automatic cmp(string what, string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("state",  "R3/R4/R5/R6/R7", int'(link_state), m_state);
            cmp("speed",  "R8", int'(link_speed), m_spd);
            cmp("duplex", "R8", int'(link_duplex), m_dpx);
            cmp("report", "R9", int'(link_report), m_rep);
            cmp("upcnt",  "R10", int'(up_count), m_up);
            cmp("dropcnt","R10", int'(drop_count), m_drop);
            cmp("poll",   "R11/R12", int'(poll_req), m_poll);
            cmp("window", "R11", int'(polling), m_act);
        end
    end

    initial begin
        tick = 1'b0;
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    task automatic send(input logic [15:0] s, input logic [4:0] v);
        @(negedge clk);
        samp_valid = 1'b1; samp_status = s; samp_vendor = v;
        @(negedge clk);
        samp_valid = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    localparam logic [15:0] ST_UP    = 16'h782D;
    localparam logic [15:0] ST_DN    = 16'h7809;
    localparam logic [15:0] ST_NOAN  = 16'h780D;
    localparam logic [4:0]  V_100F   = 5'b11011;
    localparam logic [4:0]  V_10H    = 5'b00111;
    localparam logic [4:0]  V_BOTH   = 5'b01111;
    localparam logic [4:0]  V_NOSIG  = 5'b11001;

    initial begin
        an_enable = 1'b1; restart = 1'b0; samp_valid = 1'b0;
        samp_status = '0; samp_vendor = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cmp("reset state", "R1", int'(link_state), 0);
        cmp("reset counts", "R1", int'(up_count) + int'(drop_count), 0);
        cmp("reset window", "R1", int'(polling), 0);

        // R2/R5 first sample is a change: UNKNOWN, no report
        send(ST_UP, V_100F);
        cmp("unsettled", "R5", int'(link_state), 0);
        cmp("no report", "R9", int'(link_report), 0);
        idle(2 * SETTLE + 6);
        // R6 settled, AN complete, vendor ok -> UP
        send(ST_UP, V_100F);
        cmp("settled up", "R6", int'(link_state), 2);
        cmp("up report", "R9", int'(link_report), 1);
        cmp("speed100", "R8", int'(link_speed), 2);
        cmp("full dpx", "R8", int'(link_duplex), 2);
        cmp("up count", "R10", int'(up_count), 1);

        // R4 immediate drop
        send(ST_DN, V_100F);
        cmp("fast drop", "R4", int'(link_state), 1);
        cmp("drop count", "R10", int'(drop_count), 1);
        cmp("speed cleared", "R8", int'(link_speed), 0);

        // R9 DOWN -> UNKNOWN silent
        send(ST_UP, V_100F);
        cmp("silent unknown", "R9", int'(link_state) * 2 + int'(link_report), 0);
        idle(2 * SETTLE + 6);
        // R7 inconsistent vendor words
        send(ST_UP, V_BOTH);
        cmp("both speeds", "R7", int'(link_state), 0);
        send(ST_UP, V_NOSIG);
        cmp("no signal", "R7", int'(link_state), 0);
        send(ST_UP, V_10H);
        cmp("10 half up", "R8", int'(link_speed) * 4 + int'(link_duplex), 5);

        // R3 invalid status from UP and when settled
        send(16'hFFFF, V_10H);
        cmp("invalid drop", "R3", int'(link_state), 1);
        idle(2 * SETTLE + 6);
        send(16'hFFFF, V_10H);
        cmp("invalid settled", "R3", int'(link_state), 1);

        // R6 autonegotiation incomplete
        send(ST_NOAN, V_100F);
        idle(2 * SETTLE + 6);
        send(ST_NOAN, V_100F);
        cmp("an pending down", "R6", int'(link_state), 1);
        an_enable = 1'b0;
        send(ST_NOAN, V_100F);
        cmp("an off keeps up", "R6", int'(link_state), 2);
        an_enable = 1'b1;

        // R11/R12 restart window
        send(ST_DN, V_100F);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0; #1;
        cmp("window open", "R11", int'(polling), 1);
        idle(25);
        send(ST_UP, V_100F);
        cmp("immediate poll", "R12", int'(poll_req), 1);
        idle(2 * RESTART + 4);
        cmp("window timeout", "R11", int'(polling), 0);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        idle(2 * SETTLE + 6);
        send(ST_UP, V_100F);
        cmp("window closes on up", "R11", int'(polling) * 4 + int'(link_state), 2);
        idle(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule